// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer reached through a small synchronous register bus. A prescaler divides the clock into a fixed tick, and a 10-bit down-counter steps once per tick while the timer is not halted. When the counter runs out, the block records a timeout and starts a fresh countdown from the programmed initial value.

The first timeout only sets a status flag. If the counter runs out again while that flag is still set, the block records a second timeout and issues a one-cycle reset request. A no-reboot control bit can mask that request; the second timeout is recorded either way. Software keeps the system alive by clearing the first-timeout flag and reloading the counter before the second expiry. Reads return data in the cycle after the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the following hold. Halt (bit 11 at offset 0x08) is 1 and no-reboot (bit 0 at offset 0x08) is 1. Every status flag reads 0. The initial value at offset 0x12 reads 0x032, the count at offset 0x00 reads 0x032, and reset_req is low.
- R2: Offset 0x12 holds the initial value in bits 9:0. A write there changes only those bits. Bits 15:10 always read as zero.
- R3: A write to offset 0x12 whose bits 9:0 are below 4 leaves the stored initial value unchanged.
- R4: Any write to offset 0x00 loads the counter with the initial value and restarts the prescaler. A read of offset 0x00 returns the current count in bits 9:0, with zeros above.
- R5: Halt is cleared at edge A and set again by the write at edge B. The count then holds init − floor((B−A)/TICK_CYCLES), as long as that is not below zero.
- R6: While halt is 1 the count does not move. The register at offset 0x08 reads back all 16 bits as written.
- R7: A tick that finds the count at zero is an expiry. It loads the initial value in the same cycle. Expiries are therefore (init+1)·TICK_CYCLES cycles apart.
- R8: An expiry with the first-timeout flag clear sets that flag, which is bit 3 at offset 0x04. Writing 1 to bit 3 clears it, and writing 0 there has no effect.
- R9: An expiry with the first-timeout flag set sets the second-timeout flag, which is bit 1 at offset 0x06. Writing 1 to bit 1 clears it.
- R10: A second expiry with no-reboot at 0 and the second-timeout flag clear does two things. It drives reset_req high for exactly one cycle, and it sets the boot flag (bit 2 at offset 0x06, cleared by writing 1). No further pulse occurs until bit 1 has been cleared. The pulse follows the halt-clearing write by exactly 2·(init+1)·TICK_CYCLES cycles.
- R11: With no-reboot at 1, a second expiry gives no pulse and does not set the boot flag. It still sets the second-timeout flag.
- R12: Software that clears the first-timeout flag and reloads after each first expiry, before the next one, never causes a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is a second expiry whose timing can be checked to the exact cycle. The re-arm case is just as hard: the second-timeout flag is cleared while the first-timeout flag stays set. The bench sweeps the initial value with a four-cycle tick. It releases halt with a write whose edge it records, then compares the cycle of the reset pulse against 2·(init+1)·4. For re-arming, the bench leaves the timer running past the first pulse and clears only the second-timeout flag. It then waits for the next expiry to produce exactly one more pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef logic [ADDR_W-1:0] wd_addr_t;
  typedef logic [CNT_W-1:0]  wd_cnt_t;

  // register offsets (software visible decode)
  localparam wd_addr_t OFS_RELOAD = 5'h00;
  localparam wd_addr_t OFS_STS1   = 5'h04;
  localparam wd_addr_t OFS_STS2   = 5'h06;
  localparam wd_addr_t OFS_CTRL   = 5'h08;
  localparam wd_addr_t OFS_TMR    = 5'h12;

  // bit positions
  localparam int B_FIRST  = 3;
  localparam int B_SECOND = 1;
  localparam int B_BOOT   = 2;
  localparam int B_HALT   = 11;
  localparam int B_NOREB  = 0;

  localparam wd_cnt_t INIT_MIN = 10'd4;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wd_flags_t;

  function automatic logic init_legal(input wd_cnt_t v);
    return v >= INIT_MIN;
  endfunction

  // next count on a tick: wrap to the initial value at zero
  function automatic wd_cnt_t count_step(input wd_cnt_t cur, input wd_cnt_t init);
    return (cur == '0) ? init : cur - 1'b1;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICK_CYCLES = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                               pre_q <= '0;
    else if (!run || restart || pre_q == LAST) pre_q <= '0;
    else                                      pre_q <= pre_q + 1'b1;
  end

  assign tick = run && !restart && (pre_q == LAST);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter wd_cnt_t INIT_RST = 10'h032
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    load,
  input  wd_cnt_t init_val,
  output wd_cnt_t count,
  output logic    expire
);
  wd_cnt_t count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= INIT_RST;
    else if (load) count_q <= init_val;
    else if (tick) count_q <= count_step(count_q, init_val);
  end

  assign count  = count_q;
  assign expire = tick && !load && (count_q == '0);
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire,
  input  logic      noreb,
  input  logic      clr_first,
  input  logic      clr_second,
  input  logic      clr_boot,
  output wd_flags_t flags,
  output logic      second_hit,
  output logic      fire,
  output logic      reset_req
);
  wd_flags_t flags_q, flags_n;
  logic      req_q;

  assign second_hit = expire && flags_q.first;
  assign fire       = second_hit && !flags_q.second && !noreb;

  always_comb begin
    flags_n = flags_q;
    if (clr_first)                   flags_n.first  = 1'b0;
    if (expire && !flags_q.first)    flags_n.first  = 1'b1;
    if (clr_second)                  flags_n.second = 1'b0;
    if (second_hit)                  flags_n.second = 1'b1;
    if (clr_boot)                    flags_n.boot   = 1'b0;
    if (fire)                        flags_n.boot   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      req_q   <= fire;
    end
  end

  assign flags     = flags_q;
  assign reset_req = req_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter wd_cnt_t INIT_RST = 10'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  wd_addr_t          bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  wd_cnt_t           count,
  input  wd_flags_t         flags,
  output logic              halt,
  output logic              noreb,
  output wd_cnt_t           init_val,
  output logic              reload_wr,
  output logic              clr_first,
  output logic              clr_second,
  output logic              clr_boot,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] CTRL_RST =
    (DATA_W'(1) << B_HALT) | (DATA_W'(1) << B_NOREB);

  logic [DATA_W-1:0] ctrl_q;
  wd_cnt_t           init_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr_sts1, wr_sts2, wr_ctrl, wr_tmr;

  assign reload_wr  = bus_wr && (bus_addr == OFS_RELOAD);
  assign wr_sts1    = bus_wr && (bus_addr == OFS_STS1);
  assign wr_sts2    = bus_wr && (bus_addr == OFS_STS2);
  assign wr_ctrl    = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_tmr     = bus_wr && (bus_addr == OFS_TMR);

  assign clr_first  = wr_sts1 && bus_wdata[B_FIRST];
  assign clr_second = wr_sts2 && bus_wdata[B_SECOND];
  assign clr_boot   = wr_sts2 && bus_wdata[B_BOOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      init_q <= INIT_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_tmr && init_legal(bus_wdata[CNT_W-1:0])) init_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_RELOAD: rd_mux[CNT_W-1:0] = count;
      OFS_STS1:   rd_mux[B_FIRST]   = flags.first;
      OFS_STS2: begin
        rd_mux[B_SECOND] = flags.second;
        rd_mux[B_BOOT]   = flags.boot;
      end
      OFS_CTRL:   rd_mux            = ctrl_q;
      OFS_TMR:    rd_mux[CNT_W-1:0] = init_q;
      default:    rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign halt      = ctrl_q[B_HALT];
  assign noreb     = ctrl_q[B_NOREB];
  assign init_val  = init_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int      TICK_CYCLES = 60_000_000,
  parameter wd_cnt_t INIT_RST    = 10'h032
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        reset_req
);
  // named internal events, also observed by the bound checker
  logic      tick, expire, second_hit, fire;
  logic      halt, noreb, reload_wr;
  logic      clr_first, clr_second, clr_boot;
  wd_cnt_t   count, init_val;
  wd_flags_t flags;
  logic      flag_first, flag_second;

  assign flag_first  = flags.first;
  assign flag_second = flags.second;

  wdog_regs #(.INIT_RST(INIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count), .flags(flags),
    .halt(halt), .noreb(noreb), .init_val(init_val), .reload_wr(reload_wr),
    .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
    .bus_rdata(bus_rdata)
  );

  wdog_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_wr), .tick(tick)
  );

  wdog_countdown #(.INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(reload_wr),
    .init_val(init_val), .count(count), .expire(expire)
  );

  wdog_status u_sts (
    .clk(clk), .rst_n(rst_n), .expire(expire), .noreb(noreb),
    .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
    .flags(flags), .second_hit(second_hit), .fire(fire), .reset_req(reset_req)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
  import wdog_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    reset_req,
  input logic    flag_first,
  input logic    flag_second,
  input logic    noreb,
  input logic    halt,
  input logic    reload_wr,
  input logic    clr_first,
  input logic    expire,
  input wd_cnt_t count,
  input wd_cnt_t init_val
);
  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  assert_req_records_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> flag_second);

  assert_noreboot_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !$past(noreb));

  assert_init_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_val >= INIT_MIN);

  assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !reload_wr |=> $stable(count));

  assert_first_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_first && !clr_first |=> flag_first);

  assert_expiry_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(init_val));
endmodule

bind wdog_twostage wdog_twostage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
  .flag_first(flag_first), .flag_second(flag_second), .noreb(noreb),
  .halt(halt), .reload_wr(reload_wr), .clr_first(clr_first),
  .expire(expire), .count(count), .init_val(init_val)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  localparam int TICK = 4;
  localparam logic [4:0] A_RLD = 5'h00, A_S1 = 5'h04, A_S2 = 5'h06,
                         A_CTL = 5'h08, A_TMR = 5'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        reset_req;

  int checks = 0, fails = 0;
  int cyc = 0, pulses = 0, last_pulse = 0, wr_cyc = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  wdog_twostage #(.TICK_CYCLES(TICK)) u_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && reset_req) begin
    pulses++;
    last_pulse = cyc;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_CTL, 16'h0801);
    wr(A_S1, 16'h0008);
    wr(A_S2, 16'h0006);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 reset_req", int'(reset_req), 0);
    rd(A_CTL, v); check("R1 ctrl", v, 16'h0801);
    rd(A_TMR, v); check("R1 init", v, 16'h0032);
    rd(A_RLD, v); check("R1 count", v, 16'h0032);
    rd(A_S1, v);  check("R1 sts1", v, 0);
    rd(A_S2, v);  check("R1 sts2", v, 0);

    // R2 / R3 initial value programming
    for (int t = 0; t < 4; t++) begin
      wr(A_TMR, 16'(t));
      rd(A_TMR, v); check("R3 illegal init kept", v, 16'h0032);
    end
    wr(A_TMR, 16'hFC05); rd(A_TMR, v); check("R2 upper bits zero", v, 16'h0005);
    wr(A_TMR, 16'h03FF); rd(A_TMR, v); check("R2 max init", v, 16'h03FF);
    wr(A_TMR, 16'hFC00); rd(A_TMR, v); check("R3 zero low field kept", v, 16'h03FF);
    wr(A_TMR, 16'h0004); rd(A_TMR, v); check("R3 min legal", v, 16'h0004);

    // R6 control readback
    wr(A_CTL, 16'hFFFF); rd(A_CTL, v); check("R6 ctrl readback", v, 16'hFFFF);
    wr(A_CTL, 16'h0801); rd(A_CTL, v); check("R6 ctrl readback", v, 16'h0801);

    // R4 / R5 decrement sweep
    wr(A_TMR, 16'h0020);
    for (int n = 0; n < 14; n++) begin
      wr(A_RLD, 16'h0000);
      wr(A_CTL, 16'h0001);
      idle(n);
      wr(A_CTL, 16'h0801);
      rd(A_RLD, v);
      check("R5 count after run", v, 16'h0020 - 16'((n + 2) / TICK));
    end
    // R6 halt holds
    idle(50);
    rd(A_RLD, v); check("R6 halted count", v, 16'h0020 - 16'(15 / TICK));
    // R4 reload
    wr(A_RLD, 16'hABCD); rd(A_RLD, v); check("R4 reload", v, 16'h0020);

    // R7 / R9 / R10 period sweep
    for (int init = 4; init < 10; init++) begin
      quiesce();
      wr(A_TMR, 16'(init));
      wr(A_RLD, 16'h0000);
      p0 = pulses;
      wr(A_CTL, 16'h0000);
      p0 = pulses;
      begin
        int a;
        a = wr_cyc;
        idle(90);
        check("R10 one pulse", pulses - p0, 1);
        check("R7 R10 pulse cycle", last_pulse - a, 2 * (init + 1) * TICK);
      end
      wr(A_CTL, 16'h0801);
      rd(A_S2, v); check("R9 R10 sts2 set", v, 16'h0006);
      rd(A_S1, v); check("R8 sts1 set", v, 16'h0008);
    end

    // R11 no-reboot masks request
    quiesce();
    wr(A_TMR, 16'h0004); wr(A_RLD, 16'h0000);
    p0 = pulses;
    wr(A_CTL, 16'h0001);
    idle(60);
    wr(A_CTL, 16'h0801);
    check("R11 no pulse", pulses - p0, 0);
    rd(A_S2, v); check("R11 second recorded, no boot", v, 16'h0002);
    rd(A_S1, v); check("R8 first set", v, 16'h0008);

    // R8 / R9 write-1-to-clear
    wr(A_S1, 16'h0000);  rd(A_S1, v); check("R8 write 0 no effect", v, 16'h0008);
    wr(A_S1, 16'hFFF7);  rd(A_S1, v); check("R8 other bits no effect", v, 16'h0008);
    wr(A_S1, 16'h0008);  rd(A_S1, v); check("R8 cleared", v, 16'h0000);
    wr(A_S2, 16'h0002);  rd(A_S2, v); check("R9 cleared", v, 16'h0000);

    // R10 re-arm only after clearing the second flag
    quiesce();
    wr(A_TMR, 16'h0004); wr(A_RLD, 16'h0000);
    p0 = pulses;
    wr(A_CTL, 16'h0000);
    idle(60);
    check("R10 first pulse", pulses - p0, 1);
    idle(60);
    check("R10 no repeat while second set", pulses - p0, 1);
    wr(A_S2, 16'h0002);
    idle(30);
    check("R10 re-armed pulse", pulses - p0, 2);
    wr(A_CTL, 16'h0801);
    rd(A_S2, v); check("R10 boot kept", v, 16'h0006);

    // R12 serviced watchdog never resets
    quiesce();
    wr(A_TMR, 16'h0006); wr(A_RLD, 16'h0000);
    p0 = pulses;
    wr(A_CTL, 16'h0000);
    for (int k = 0; k < 6; k++) begin
      idle(35);
      rd(A_S1, v); check("R12 first expiry seen", v, 16'h0008);
      wr(A_S1, 16'h0008);
      wr(A_RLD, 16'h0000);
    end
    wr(A_CTL, 16'h0801);
    check("R12 no pulse", pulses - p0, 0);
    rd(A_S2, v); check("R12 no second", v, 16'h0000);

    done = 1;
    summary();
  end
endmodule